// File: doc/BRIEF.md
# Unaligned Load Splitter

This block is the read path between a register-file port and a memory bus that moves only whole 32-bit words at word-aligned addresses. A load request carries a byte address and an access size (byte, halfword or word). An access that fits inside one bus word is served with a single bus read. An access that crosses a word boundary is served with two reads, first the containing word and then the word after it. A byte-lane merge then places the requested bytes into the low positions of the result, little-endian, and clears the bits above them.

A strict input selects a checking mode. In that mode any request whose address is not a multiple of its own size completes at once with a fault indication and makes no bus access. Requests arrive over a valid/ready handshake, and only one request is in flight at a time. Completion is a one-cycle pulse that carries the result, or the fault.

Top module: `load_splitter`

## Requirements
- R1: While reset is asserted, `req_ready_o` is 1 and `bus_req_o` and `done_o` are 0.
- R2: When strict mode is off, an access that fits in one word makes exactly one bus read, at the address with its two low bits cleared. Such accesses are a byte at any offset, a halfword at offset 0, 1 or 2, and a word at offset 0.
- R3: A halfword at offset 3, or a word at offset 1, 2 or 3, makes exactly two bus reads: the containing word address first, then that address plus 4, modulo 2^32. The second read is issued only after the data of the first has returned.
- R4: On completion without a fault, result byte k (bits 8k+7..8k) holds the memory byte at request address plus k, for k below the access size in bytes. All higher result bits are 0. Bus data byte j (bits 8j+7..8j) is the memory byte at word address plus j.
- R5: With `strict_i`=1 at acceptance, a misaligned request completes with `fault_o`=1, `data_o`=0 and no bus read. A request is misaligned when it is a halfword at an odd address, or a word at an address that is not a multiple of 4.
- R6: With `strict_i`=1, aligned requests complete normally, with no fault and the same reads and result as in R2 and R4.
- R7: `req_ready_o` drops in the cycle after a request is accepted and stays low until completion.
- R8: `done_o` is a one-cycle pulse. `fault_o` is only ever high together with `done_o`.
- R9: Size code 0 is a byte, 1 a halfword, 2 a word. Code 3 is handled exactly like a word.
- R10: `bus_req_o` is a one-cycle pulse for each read, and `bus_raddr_o` always has its two low bits at 0 while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strict_i | input | 1 | Fault on misaligned requests instead of splitting them |
| req_valid_i | input | 1 | Load request valid |
| req_ready_o | output | 1 | Ready to accept a request |
| req_addr_i | input | ADDR_W | Byte address of the load |
| req_size_i | input | 2 | Access size code |
| done_o | output | 1 | Completion pulse |
| fault_o | output | 1 | Alignment fault, valid with done_o |
| data_o | output | DATA_W | Zero-extended load result, valid with done_o |
| bus_req_o | output | 1 | Bus read strobe |
| bus_raddr_o | output | ADDR_W | Word-aligned bus read address |
| bus_dvalid_i | input | 1 | Bus read data valid |
| bus_rdata_i | input | DATA_W | Bus read data |

## Verification
Loads are run at every byte offset for each size. This separates the single-read cases (bytes, halfwords at offsets 1 and 2) from the two-read cases, and it shows whether the merge takes bytes from the correct word and lane. The same offsets are run again with strict mode on, so that a halfword at offset 1, which fits in one word but is still misaligned, shows that faulting follows alignment and not word crossing. Different bus latencies, the reserved size code, and a word that wraps past the top of the address space check the ordering of the reads and the wrap of the address increment.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE_A,
    ST_WAIT_A,
    ST_ISSUE_B,
    ST_WAIT_B,
    ST_RESP
  } state_e;

  // Number of bytes an access covers, capped at the bus width.
  function automatic int unsigned span_bytes(input logic [1:0] sz, input int unsigned lanes);
    int unsigned n;
    n = 32'd1 << sz;
    if (n > lanes) n = lanes;
    return n;
  endfunction

endpackage

// File: rtl/lsp_geom.sv
module lsp_geom
  import lsp_pkg::*;
#(
  parameter int LANES = 4,
  parameter int OFF_W = $clog2(LANES)
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  output logic             misaligned_o,
  output logic             straddle_o
);

  int unsigned n_w;

  always_comb begin
    n_w          = span_bytes(size_i, 32'(LANES));
    misaligned_o = (32'(off_i) & (n_w - 32'd1)) != 32'd0;
    straddle_o   = (32'(off_i) + n_w) > 32'(LANES);
  end

endmodule

// File: rtl/lsp_lane_merge.sv
module lsp_lane_merge
  import lsp_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int OFF_W  = $clog2(LANES),
  parameter int DATA_W = LANES * 8
) (
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        size_i,
  output logic [DATA_W-1:0] data_o
);

  logic [2*DATA_W-1:0] pair;
  logic [DATA_W-1:0]   win;
  int unsigned         n_w;

  assign pair = {hi_i, lo_i};
  assign win  = DATA_W'(pair >> {off_i, 3'b000});

  always_comb n_w = span_bytes(size_i, 32'(LANES));

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign data_o[k*8 +: 8] = (32'(k) < n_w) ? win[k*8 +: 8] : 8'h00;
    end
  endgenerate

endmodule

// File: rtl/lsp_ctrl.sv
module lsp_ctrl
  import lsp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  input  logic strict_i,
  input  logic misaligned_i,
  input  logic straddle_i,
  input  logic dvalid_i,
  output logic ready_o,
  output logic bus_req_o,
  output logic second_o,
  output logic cap_lo_o,
  output logic cap_hi_o,
  output logic done_o,
  output logic fault_o
);

  state_e state_q, state_d;
  logic   split_q, split_d;
  logic   fault_q, fault_d;

  always_comb begin
    state_d  = state_q;
    split_d  = split_q;
    fault_d  = fault_q;
    cap_lo_o = 1'b0;
    cap_hi_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (fire_i) begin
          fault_d = strict_i & misaligned_i;
          split_d = straddle_i & ~(strict_i & misaligned_i);
          state_d = (strict_i & misaligned_i) ? ST_RESP : ST_ISSUE_A;
        end
      end
      ST_ISSUE_A: state_d = ST_WAIT_A;
      ST_WAIT_A: begin
        if (dvalid_i) begin
          cap_lo_o = 1'b1;
          state_d  = split_q ? ST_ISSUE_B : ST_RESP;
        end
      end
      ST_ISSUE_B: state_d = ST_WAIT_B;
      ST_WAIT_B: begin
        if (dvalid_i) begin
          cap_hi_o = 1'b1;
          state_d  = ST_RESP;
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      split_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      split_q <= split_d;
      fault_q <= fault_d;
    end
  end

  assign ready_o   = (state_q == ST_IDLE);
  assign bus_req_o = (state_q == ST_ISSUE_A) || (state_q == ST_ISSUE_B);
  assign second_o  = (state_q == ST_ISSUE_B);
  assign done_o    = (state_q == ST_RESP);
  assign fault_o   = (state_q == ST_RESP) & fault_q;

endmodule

// File: rtl/load_splitter.sv
module load_splitter
  import lsp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strict_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  output logic              done_o,
  output logic              fault_o,
  output logic [DATA_W-1:0] data_o,
  output logic              bus_req_o,
  output logic [ADDR_W-1:0] bus_raddr_o,
  input  logic              bus_dvalid_i,
  input  logic [DATA_W-1:0] bus_rdata_i
);

  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(LANES);
  localparam int WIDX_W = ADDR_W - OFF_W;

  logic              fire;
  logic              misaligned, straddle;
  logic              second, cap_lo, cap_hi;
  logic [WIDX_W-1:0] widx_q, widx_sel;
  logic [OFF_W-1:0]  off_q;
  logic [1:0]        size_q;
  logic [DATA_W-1:0] lo_q, hi_q, merged;

  assign fire = req_valid_i & req_ready_o;

  lsp_geom #(.LANES(LANES), .OFF_W(OFF_W)) u_geom (
    .off_i        (req_addr_i[OFF_W-1:0]),
    .size_i       (req_size_i),
    .misaligned_o (misaligned),
    .straddle_o   (straddle)
  );

  lsp_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .fire_i       (fire),
    .strict_i     (strict_i),
    .misaligned_i (misaligned),
    .straddle_i   (straddle),
    .dvalid_i     (bus_dvalid_i),
    .ready_o      (req_ready_o),
    .bus_req_o    (bus_req_o),
    .second_o     (second),
    .cap_lo_o     (cap_lo),
    .cap_hi_o     (cap_hi),
    .done_o       (done_o),
    .fault_o      (fault_o)
  );

  // Request and data holding registers, each with its own enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      widx_q <= '0;
      off_q  <= '0;
      size_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      if (fire) begin
        widx_q <= req_addr_i[ADDR_W-1:OFF_W];
        off_q  <= req_addr_i[OFF_W-1:0];
        size_q <= req_size_i;
      end
      if (cap_lo) lo_q <= bus_rdata_i;
      if (fire)        hi_q <= '0;
      else if (cap_hi) hi_q <= bus_rdata_i;
    end
  end

  assign widx_sel    = widx_q + WIDX_W'(second);
  assign bus_raddr_o = {widx_sel, {OFF_W{1'b0}}};

  lsp_lane_merge #(.LANES(LANES), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_merge (
    .lo_i   (lo_q),
    .hi_i   (hi_q),
    .off_i  (off_q),
    .size_i (size_q),
    .data_o (merged)
  );

  assign data_o = (done_o && !fault_o) ? merged : '0;

endmodule

// File: rtl/load_splitter_chk.sv
module load_splitter_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strict_i,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [1:0]        req_size_i,
  input logic              done_o,
  input logic              fault_o,
  input logic [DATA_W-1:0] data_o,
  input logic              bus_req_o,
  input logic [ADDR_W-1:0] bus_raddr_o,
  input logic              bus_dvalid_i,
  input logic [DATA_W-1:0] bus_rdata_i
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  logic [1:0]        nrd_q;
  logic [ADDR_W-1:0] last_q;
  logic [1:0]        sz_q;
  logic              fire;

  assign fire = req_valid_i & req_ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nrd_q  <= '0;
      last_q <= '0;
      sz_q   <= '0;
    end else begin
      if (fire) begin
        nrd_q <= '0;
        sz_q  <= req_size_i;
      end else if (bus_req_o) begin
        nrd_q  <= nrd_q + 2'd1;
        last_q <= bus_raddr_o;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (req_ready_o && !bus_req_o && !done_o);
    end
  end

  p_word_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o |-> bus_raddr_o[OFF_W-1:0] == '0);

  p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o |=> !bus_req_o);

  p_second_next_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && nrd_q == 2'd1) |-> bus_raddr_o == last_q + ADDR_W'(LANES));

  p_two_reads_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o |-> nrd_q < 2'd2);

  p_fault_no_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (nrd_q == 2'd0 && data_o == '0));

  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !req_ready_o);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_fault_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> done_o);

  p_byte_zero_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !fault_o && sz_q == 2'd0) |-> data_o[DATA_W-1:8] == '0);

endmodule

bind load_splitter load_splitter_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/load_splitter_test.sv
`timescale 1ns/1ps
module load_splitter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strict_i = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        done, fault;
  logic [31:0] data;
  logic        bus_req;
  logic [31:0] bus_raddr;
  logic        bus_dvalid = 1'b0;
  logic [31:0] bus_rdata = '0;

  int checks = 0;
  int fails  = 0;
  int lat    = 1;
  int cnt    = 0;
  int nreads = 0;
  logic [31:0] raddr_l = '0;
  logic [31:0] exp_q[$];

  always #2 clk = ~clk;

  load_splitter uut (
    .clk(clk), .rst_n(rst_n), .strict_i(strict_i),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_size_i(req_size),
    .done_o(done), .fault_o(fault), .data_o(data),
    .bus_req_o(bus_req), .bus_raddr_o(bus_raddr),
    .bus_dvalid_i(bus_dvalid), .bus_rdata_i(bus_rdata)
  );

  function automatic logic [7:0] bval(input logic [31:0] a);
    return (a[7:0] ^ 8'hA5) + a[15:8];
  endfunction

  function automatic logic [31:0] mword(input logic [31:0] a);
    return {bval(a + 3), bval(a + 2), bval(a + 1), bval(a)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory responder: data returns lat cycles after the read strobe.
  always @(posedge clk) begin
    if (bus_req) begin
      cnt        <= lat;
      raddr_l    <= bus_raddr;
      bus_dvalid <= 1'b0;
    end else if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        bus_dvalid <= 1'b1;
        bus_rdata  <= mword(raddr_l);
      end else begin
        bus_dvalid <= 1'b0;
      end
    end else begin
      bus_dvalid <= 1'b0;
    end
  end

  // Per-clock reference comparison of bus reads against the expected sequence.
  always @(negedge clk) begin
    if (rst_n && bus_req) begin
      nreads++;
      chk(bus_raddr[1:0] == 2'b00, "R10 word-aligned bus address", bus_raddr, bus_raddr & ~32'd3);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected bus read", bus_raddr, 32'hFFFF_FFFF);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(bus_raddr == e, "R3 bus read address order", bus_raddr, e);
      end
    end
  end

  task automatic load(input logic [31:0] a, input logic [1:0] sz, input bit strict,
                      input int lt, input string tag);
    int n, off, expr, waited;
    bit mis, strad, fexp;
    logic [31:0] expd;
    n = 1 << sz;
    if (n > 4) n = 4;
    off   = int'(a & 32'd3);
    mis   = (off % n) != 0;
    strad = (off + n) > 4;
    fexp  = strict && mis;
    expd  = '0;
    for (int k = 0; k < n; k++) expd |= 32'(bval(a + 32'(k))) << (8 * k);
    if (fexp) expd = '0;
    expr = fexp ? 0 : (strad ? 2 : 1);
    if (!fexp) begin
      exp_q.push_back(a & ~32'd3);
      if (strad) exp_q.push_back((a & ~32'd3) + 32'd4);
    end
    lat    = lt;
    nreads = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    req_size  = sz;
    strict_i  = strict;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R7 busy after accept", 32'(req_ready), 32'd0);
    waited = 0;
    while (!done && waited < 64) begin
      @(negedge clk);
      waited++;
      if (!done) chk(!req_ready, "R7 not ready while in flight", 32'(req_ready), 32'd0);
    end
    chk(done, {tag, " completion seen"}, 32'(done), 32'd1);
    chk(data == expd, {tag, "/R4 result data"}, data, expd);
    chk(fault == fexp, {tag, " fault flag"}, 32'(fault), 32'(fexp));
    chk(nreads == expr, {tag, " bus read count"}, 32'(nreads), 32'(expr));
    @(negedge clk);
    chk(!done && !fault, "R8 done is a single pulse", {30'd0, done, fault}, 32'd0);
    chk(exp_q.size() == 0, {tag, " all expected reads issued"}, 32'(exp_q.size()), 32'd0);
    exp_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(req_ready, "R1 ready in reset", 32'(req_ready), 32'd1);
    chk(!bus_req, "R1 no bus read in reset", 32'(bus_req), 32'd0);
    chk(!done, "R1 no done in reset", 32'(done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Non-strict, every offset of every size.
    for (int o = 0; o < 4; o++) load(32'h0000_1230 + 32'(o), 2'd0, 1'b0, 1, "R2");
    for (int o = 0; o < 3; o++) load(32'h0000_2460 + 32'(o), 2'd1, 1'b0, 2, "R2");
    load(32'h0000_2463, 2'd1, 1'b0, 1, "R3");
    load(32'h0000_3a00, 2'd2, 1'b0, 1, "R2");
    for (int o = 1; o < 4; o++) load(32'h0000_3a00 + 32'(o), 2'd2, 1'b0, 3, "R3");
    // Word wrapping past the top of the address space.
    load(32'hFFFF_FFFE, 2'd2, 1'b0, 1, "R3");
    // Reserved size code behaves as a word.
    load(32'h0000_5100, 2'd3, 1'b0, 1, "R9");
    load(32'h0000_5102, 2'd3, 1'b0, 2, "R9");
    load(32'h0000_5101, 2'd3, 1'b1, 1, "R9");

    // Strict mode: misaligned faults, aligned proceeds.
    load(32'h0000_6001, 2'd1, 1'b1, 1, "R5");
    load(32'h0000_6003, 2'd1, 1'b1, 1, "R5");
    load(32'h0000_6002, 2'd2, 1'b1, 1, "R5");
    load(32'h0000_6001, 2'd2, 1'b1, 1, "R5");
    load(32'h0000_6004, 2'd2, 1'b1, 2, "R6");
    load(32'h0000_6002, 2'd1, 1'b1, 1, "R6");
    load(32'h0000_6003, 2'd0, 1'b1, 1, "R6");
    // Back to non-strict after a fault: the same address now splits.
    load(32'h0000_6001, 2'd2, 1'b0, 1, "R3");

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule